// File: doc/BRIEF.md
# DRAM Power-State and Calibration Sequencer

This block steps a DDR3 memory device through its power-up bring-up, its self-refresh entry and exit, and its periodic short impedance calibration. It owns the clock-enable pin toward the device, picks which command the controller's command path should place on the bus in each cycle (NOP, MRS, ZQCL, ZQCS, self-refresh entry, self-refresh exit), and tells the clock generator when the memory clock may be stopped. Every wait it enforces is the larger of a clock-cycle floor and a nanosecond figure, converted to cycles at elaboration from the clock period parameter. During every wait only NOP is sent.

After a self-refresh exit the block raises readiness in two steps. The first step, `ready_no_dll`, allows commands that do not depend on a locked delay-locked loop. The second step, `ready_dll`, allows all commands. The controller holds `sr_enter_req` and `sr_exit_req` as levels until they take effect. It pulses `zqcs_req` for one cycle, and that request is kept pending until the block is idle, so it is never lost. All pins are plain control and status levels: there is no data stream, and so no valid/ready back-pressure.

With the default parameters (5 ns clock, 110 ns refresh cycle, CKE minimum 3 cycles) the waits come to the following cycle counts:

| Wait | Cycles |
|---|---|
| CKE rise to first command, and self-refresh exit to `ready_no_dll` | 24 |
| Between mode-register loads | 12 |
| Initial long calibration | 512 |
| Short calibration | 64 |
| Clock hold after entry, and stable clock before any exit | 5 |
| Self-refresh exit to `ready_dll` | 512 |

Top module: `dram_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `cke`=0, `cmd`=NOP (0), `clk_en_req`=1, and both ready outputs are 0.
- R2: `cke` rises on the clock edge at which `clk_stable` has been sampled high on 5 consecutive edges. A low sample restarts the count.
- R3: The first MRS comes 24 cycles after `cke` rises on reset exit.
- R4: There are four MRS commands, 12 cycles apart. `mr_sel` carries the mode register number in the order 2, 3, 1, 0. ZQCL follows 12 cycles after the last MRS.
- R5: Both ready outputs rise together 512 cycles after ZQCL.
- R6: The command codes are NOP=0, MRS=1, ZQCL=2, ZQCS=3, SRE=4, SRX=5. A command other than NOP lasts exactly one cycle and is always followed by NOP.
- R7: In idle, a `zqcs_req` sampled on an edge gives ZQCS on that same edge. Both ready outputs drop at that edge and come back 64 cycles later.
- R8: In idle, a sampled `sr_enter_req` gives SRE on that edge. `cke` goes low on the same edge, and both ready outputs drop.
- R9: `clk_en_req` falls 5 cycles after SRE. Until an exit request is sampled, `clk_en_req` stays 0, `cke` stays 0 and `cmd` stays NOP.
- R10: `clk_en_req` rises on the edge at which `sr_exit_req` is first sampled in self-refresh. SRX is issued with `cke` high on the 5th consecutive high sample of `clk_stable` after that edge.
- R11: `ready_no_dll` rises 24 cycles after SRX, while `ready_dll` is still 0. `ready_dll` rises 512 cycles after SRX, and the block is then idle again.
- R12: A `zqcs_req` pulse that arrives outside idle is held. Its ZQCS is issued one cycle after `ready_dll` returns.
- R13: In idle, a pending or new short-calibration request is served before a self-refresh entry request. SRE then follows 65 cycles after ZQCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_stable | input | 1 | Clock generator reports a stable memory clock |
| sr_enter_req | input | 1 | Level request to enter self-refresh |
| sr_exit_req | input | 1 | Level request to leave self-refresh |
| zqcs_req | input | 1 | Pulse requesting a short calibration |
| cmd | output | 3 | Command to place on the bus this cycle |
| mr_sel | output | 2 | Mode register number while `cmd` is MRS, else 0 |
| cke | output | 1 | Clock enable to the memory device |
| clk_en_req | output | 1 | Request to keep the memory clock running |
| ready_no_dll | output | 1 | Commands that need no locked DLL are allowed |
| ready_dll | output | 1 | All commands are allowed |

## Verification
A wrong internal state shows up at the ports as a wrong command spacing. A wait timer loaded with the wrong count moves the next MRS, ZQCL, ZQCS or SRX by that error, and a missed wait makes a non-NOP command appear early, within one wait period. A state machine stuck in a wait leaves `cmd` at NOP and the ready outputs low forever. A lost calibration request shows as a missing ZQCS on the cycle after `ready_dll` returns. A wrong readiness order shows as `ready_dll` high while `ready_no_dll` is low, or as a `ready_no_dll` edge that is not exactly 24 cycles after SRX, visible within one exit window of 512 cycles.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_ZQCL = 3'd2,
    CMD_ZQCS = 3'd3,
    CMD_SRE  = 3'd4,
    CMD_SRX  = 3'd5
  } dps_cmd_e;

  typedef enum logic [3:0] {
    ST_RESET_WAIT,
    ST_CKE_HIGH_WAIT,
    ST_MRS_LOAD,
    ST_ZQINIT,
    ST_IDLE,
    ST_SR_ENTER,
    ST_SR_ACTIVE,
    ST_SR_EXIT_WAIT,
    ST_ZQ_SHORT
  } dps_state_e;

  // Cycle floors and nanosecond parts of each wait
  localparam int XPR_FLOOR_CK   = 5;
  localparam int XPR_EXTRA_NS   = 10;
  localparam int MOD_FLOOR_CK   = 12;
  localparam int MOD_NS         = 15;
  localparam int ZQINIT_NS      = 640;
  localparam int ZQSHORT_NS     = 80;
  localparam int CLKHOLD_FLOOR  = 5;
  localparam int CLKHOLD_NS     = 10;
  localparam int NUM_MRS        = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // larger of a cycle floor and a nanosecond time rounded up to cycles
  function automatic int wait_ck(input int floor_ck, input int ns, input int clk_ps);
    int t;
    t = (ns * 1000 + clk_ps - 1) / clk_ps;
    return imax(floor_ck, t);
  endfunction

  // mode registers are loaded in the order 2, 3, 1, 0
  function automatic logic [1:0] mr_order(input int k);
    case (k)
      0:       return 2'd2;
      1:       return 2'd3;
      2:       return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dps_timer.sv
module dps_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dps_stable_filter.sv
module dps_stable_filter #(
  parameter int N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clk_stable,
  output logic ok
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] RELOAD = W'(N - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= RELOAD;
    else if (arm)             cnt <= RELOAD;
    else if (!clk_stable)     cnt <= RELOAD;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign ok = clk_stable && (cnt == '0);
endmodule

// File: rtl/dps_exit_ctr.sv
module dps_exit_ctr #(
  parameter int N_XS    = 24,
  parameter int N_XSDLL = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic at_xs,
  output logic at_dll
);
  localparam int W = $clog2(N_XSDLL + 1);
  localparam logic [W-1:0] LIM_XS  = W'(N_XS);
  localparam logic [W-1:0] LIM_DLL = W'(N_XSDLL);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                             cnt <= '0;
    else if (start)                         cnt <= W'(1);
    else if (cnt != '0 && cnt != LIM_DLL)   cnt <= cnt + 1'b1;
  end

  assign at_xs  = (cnt == LIM_XS);
  assign at_dll = (cnt == LIM_DLL);
endmodule

// File: rtl/dps_zq_pend.sv
module dps_zq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending | req) & ~take;
  end
endmodule

// File: rtl/dram_pwr_seq.sv
module dram_pwr_seq
  import dps_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int TRFC_NS     = 110,
  parameter int CKE_MIN_CK  = 3,
  parameter int DLL_LOCK_CK = 512,
  parameter int ZQ_INIT_CK  = 512,
  parameter int ZQ_SHORT_CK = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_stable,
  input  logic       sr_enter_req,
  input  logic       sr_exit_req,
  input  logic       zqcs_req,
  output logic [2:0] cmd,
  output logic [1:0] mr_sel,
  output logic       cke,
  output logic       clk_en_req,
  output logic       ready_no_dll,
  output logic       ready_dll
);
  localparam int N_XPR   = wait_ck(XPR_FLOOR_CK, TRFC_NS + XPR_EXTRA_NS, CLK_PS);
  localparam int N_MOD   = wait_ck(MOD_FLOOR_CK, MOD_NS, CLK_PS);
  localparam int N_ZQI   = wait_ck(ZQ_INIT_CK, ZQINIT_NS, CLK_PS);
  localparam int N_ZQS   = wait_ck(ZQ_SHORT_CK, ZQSHORT_NS, CLK_PS);
  localparam int N_CKSR  = wait_ck(CLKHOLD_FLOOR, CLKHOLD_NS, CLK_PS);
  localparam int N_CKESR = CKE_MIN_CK + 1;
  localparam int N_SRE   = imax(N_CKSR, N_CKESR);
  localparam int N_XS    = N_XPR;
  localparam int N_XSDLL = imax(DLL_LOCK_CK, N_XS + 1);
  localparam int T_MAX   = imax(imax(N_XPR, N_MOD), imax(imax(N_ZQI, N_ZQS), N_SRE));
  localparam int TW      = $clog2(T_MAX + 1);
  localparam int MW      = $clog2(NUM_MRS + 1);

  dps_state_e     st, st_n;
  dps_cmd_e       cmd_q, cmd_n;
  logic [1:0]     mr_q, mr_n;
  logic [MW-1:0]  mrs_cnt, mrs_cnt_n;
  logic           cke_q, cke_n, clken_q, clken_n;
  logic           rnd_q, rnd_n, rd_q, rd_n;
  logic           waking, waking_n;

  logic           t_load, t_done;
  logic [TW-1:0]  t_val;
  logic           arm, stab_ok;
  logic           x_start, at_xs, at_dll;
  logic           take, zq_pend;

  dps_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  dps_stable_filter #(.N(N_CKSR)) u_stab (
    .clk(clk), .rst_n(rst_n), .arm(arm), .clk_stable(clk_stable), .ok(stab_ok)
  );

  dps_exit_ctr #(.N_XS(N_XS), .N_XSDLL(N_XSDLL)) u_exit (
    .clk(clk), .rst_n(rst_n), .start(x_start), .at_xs(at_xs), .at_dll(at_dll)
  );

  dps_zq_pend u_zq (
    .clk(clk), .rst_n(rst_n), .req(zqcs_req), .take(take), .pending(zq_pend)
  );

  always_comb begin
    st_n      = st;
    cmd_n     = CMD_NOP;
    mr_n      = 2'd0;
    mrs_cnt_n = mrs_cnt;
    cke_n     = cke_q;
    clken_n   = clken_q;
    rnd_n     = rnd_q;
    rd_n      = rd_q;
    waking_n  = waking;
    t_load    = 1'b0;
    t_val     = '0;
    arm       = 1'b0;
    x_start   = 1'b0;
    take      = 1'b0;
    case (st)
      ST_RESET_WAIT: begin
        clken_n = 1'b1;
        if (stab_ok) begin
          cke_n  = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(N_XPR - 1);
          st_n   = ST_CKE_HIGH_WAIT;
        end
      end
      ST_CKE_HIGH_WAIT: begin
        if (t_done) begin
          cmd_n     = CMD_MRS;
          mr_n      = mr_order(0);
          mrs_cnt_n = MW'(1);
          t_load    = 1'b1;
          t_val     = TW'(N_MOD - 1);
          st_n      = ST_MRS_LOAD;
        end
      end
      ST_MRS_LOAD: begin
        if (t_done) begin
          t_load = 1'b1;
          if (mrs_cnt == MW'(NUM_MRS)) begin
            cmd_n = CMD_ZQCL;
            t_val = TW'(N_ZQI - 1);
            st_n  = ST_ZQINIT;
          end else begin
            cmd_n     = CMD_MRS;
            mr_n      = mr_order(int'(mrs_cnt));
            mrs_cnt_n = mrs_cnt + 1'b1;
            t_val     = TW'(N_MOD - 1);
          end
        end
      end
      ST_ZQINIT: begin
        if (t_done) begin
          rnd_n = 1'b1;
          rd_n  = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (zq_pend || zqcs_req) begin
          cmd_n  = CMD_ZQCS;
          take   = 1'b1;
          rnd_n  = 1'b0;
          rd_n   = 1'b0;
          t_load = 1'b1;
          t_val  = TW'(N_ZQS - 1);
          st_n   = ST_ZQ_SHORT;
        end else if (sr_enter_req) begin
          cmd_n  = CMD_SRE;
          cke_n  = 1'b0;
          rnd_n  = 1'b0;
          rd_n   = 1'b0;
          t_load = 1'b1;
          t_val  = TW'(N_SRE - 1);
          st_n   = ST_SR_ENTER;
        end
      end
      ST_ZQ_SHORT: begin
        if (t_done) begin
          rnd_n = 1'b1;
          rd_n  = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_SR_ENTER: begin
        if (t_done) begin
          clken_n = 1'b0;
          st_n    = ST_SR_ACTIVE;
        end
      end
      ST_SR_ACTIVE: begin
        if (!waking) begin
          if (sr_exit_req) begin
            clken_n  = 1'b1;
            arm      = 1'b1;
            waking_n = 1'b1;
          end
        end else if (stab_ok) begin
          cmd_n    = CMD_SRX;
          cke_n    = 1'b1;
          x_start  = 1'b1;
          waking_n = 1'b0;
          st_n     = ST_SR_EXIT_WAIT;
        end
      end
      ST_SR_EXIT_WAIT: begin
        if (at_xs) rnd_n = 1'b1;
        if (at_dll) begin
          rd_n = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_RESET_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_RESET_WAIT;
      cmd_q   <= CMD_NOP;
      mr_q    <= 2'd0;
      mrs_cnt <= '0;
      cke_q   <= 1'b0;
      clken_q <= 1'b1;
      rnd_q   <= 1'b0;
      rd_q    <= 1'b0;
      waking  <= 1'b0;
    end else begin
      st      <= st_n;
      cmd_q   <= cmd_n;
      mr_q    <= mr_n;
      mrs_cnt <= mrs_cnt_n;
      cke_q   <= cke_n;
      clken_q <= clken_n;
      rnd_q   <= rnd_n;
      rd_q    <= rd_n;
      waking  <= waking_n;
    end
  end

  assign cmd          = cmd_q;
  assign mr_sel       = mr_q;
  assign cke          = cke_q;
  assign clk_en_req   = clken_q;
  assign ready_no_dll = rnd_q;
  assign ready_dll    = rd_q;
endmodule

// File: rtl/dram_pwr_seq_chk.sv
module dram_pwr_seq_chk #(
  parameter int N_XS    = 24,
  parameter int N_XSDLL = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable,
  input logic [2:0] cmd,
  input logic       cke,
  input logic       clk_en_req,
  input logic       ready_no_dll,
  input logic       ready_dll
);
  localparam int SW = $clog2(N_XSDLL + 2);
  localparam logic [SW-1:0] SMAX = SW'(N_XSDLL + 1);

  logic [SW-1:0] since_srx;
  logic          in_exit;

  // cycles since the last SRX seen on the bus, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_srx <= '0;
      in_exit   <= 1'b0;
    end else begin
      if (cmd == 3'd5) begin
        since_srx <= SW'(1);
        in_exit   <= 1'b1;
      end else begin
        if (since_srx != '0 && since_srx != SMAX) since_srx <= since_srx + 1'b1;
        if (ready_dll) in_exit <= 1'b0;
      end
    end
  end

  assert_single_cycle_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'd0) |=> (cmd == 3'd0));

  assert_known_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd <= 3'd5));

  assert_dll_implies_nodll_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready_dll |-> ready_no_dll);

  assert_cke_fall_is_sre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == 3'd4));

  assert_gate_only_cke_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_req |-> !cke);

  assert_cke_rise_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (clk_en_req && $past(clk_stable)));

  assert_idle_only_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 || cmd == 3'd4) |-> $past(ready_dll));

  assert_xs_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_no_dll) && in_exit) |-> (since_srx == SW'(N_XS)));

  assert_xsdll_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_dll) && in_exit) |-> (since_srx == SW'(N_XSDLL)));
endmodule

bind dram_pwr_seq dram_pwr_seq_chk #(.N_XS(N_XS), .N_XSDLL(N_XSDLL)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .cmd(cmd), .cke(cke),
  .clk_en_req(clk_en_req), .ready_no_dll(ready_no_dll), .ready_dll(ready_dll)
);

// File: tb/dram_pwr_seq_bench.sv
`timescale 1ns/1ps
module dram_pwr_seq_bench;
  localparam int C_NOP = 0, C_MRS = 1, C_ZQCL = 2, C_ZQCS = 3, C_SRE = 4, C_SRX = 5;
  localparam int W_CKE = 0, W_CLKEN_LO = 1, W_CLKEN_HI = 2, W_RND = 3, W_RD = 4, W_CMD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_stable = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0, zqcs_req = 1'b0;
  logic [2:0] cmd;
  logic [1:0] mr_sel;
  logic cke, clk_en_req, ready_no_dll, ready_dll;

  int nvec = 0, nbad = 0, cyc = 0, r6_bad = 0;
  logic [2:0] prev_cmd = 3'd0;

  always #2.5 clk = ~clk;

  dram_pwr_seq u_dram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .zqcs_req(zqcs_req), .cmd(cmd), .mr_sel(mr_sel),
    .cke(cke), .clk_en_req(clk_en_req), .ready_no_dll(ready_no_dll), .ready_dll(ready_dll)
  );

  // watchdog and command-shape monitor for R6
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && ((prev_cmd != 3'd0 && cmd != 3'd0) || cmd > 3'd5)) r6_bad++;
    prev_cmd = cmd;
    if (cyc > 100000) begin
      nbad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic bit probe(input int what, input int code);
    case (what)
      W_CKE:      return cke;
      W_CLKEN_LO: return !clk_en_req;
      W_CLKEN_HI: return clk_en_req;
      W_RND:      return ready_no_dll;
      W_RD:       return ready_dll;
      default:    return int'(cmd) == code;
    endcase
  endfunction

  // count edges until the probed condition is seen
  task automatic wait_for(input int what, input int code, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!probe(what, code) && n < 3000);
  endtask

  task automatic t_reset();
    edges(3);
    expect_eq("R1 cke", cke, 0);
    expect_eq("R1 cmd", cmd, C_NOP);
    expect_eq("R1 clk_en_req", clk_en_req, 1);
    expect_eq("R1 ready", {ready_no_dll, ready_dll}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    int n;
    logic [1:0] order [4] = '{2'd2, 2'd3, 2'd1, 2'd0};
    edges(8);
    expect_eq("R2 cke before stable", cke, 0);
    clk_stable = 1'b1; edges(3);
    clk_stable = 1'b0; edges(1);
    expect_eq("R2 cke after glitch", cke, 0);
    clk_stable = 1'b1;
    wait_for(W_CKE, 0, n);
    expect_eq("R2 stable samples to cke", n, 5);
    wait_for(W_CMD, C_MRS, n);
    expect_eq("R3 cke to first MRS", n, 24);
    expect_eq("R4 first mr_sel", mr_sel, order[0]);
    for (int k = 1; k < 4; k++) begin
      wait_for(W_CMD, C_MRS, n);
      expect_eq("R4 MRS spacing", n, 12);
      expect_eq("R4 mr_sel order", mr_sel, order[k]);
    end
    wait_for(W_CMD, C_ZQCL, n);
    expect_eq("R4 last MRS to ZQCL", n, 12);
    wait_for(W_RND, 0, n);
    expect_eq("R5 ZQCL to ready", n, 512);
    expect_eq("R5 ready_dll together", ready_dll, 1);
  endtask

  task automatic t_zq_idle();
    int n;
    zqcs_req = 1'b1;
    wait_for(W_CMD, C_ZQCS, n);
    zqcs_req = 1'b0;
    expect_eq("R7 request to ZQCS", n, 1);
    expect_eq("R7 ready dropped", {ready_no_dll, ready_dll}, 0);
    wait_for(W_RD, 0, n);
    expect_eq("R7 ZQCS duration", n, 64);
  endtask

  task automatic t_sr_cycle(input bit zq_inside);
    int n, bad;
    sr_enter_req = 1'b1;
    wait_for(W_CMD, C_SRE, n);
    sr_enter_req = 1'b0;
    expect_eq("R8 request to SRE", n, 1);
    expect_eq("R8 cke low with SRE", cke, 0);
    expect_eq("R8 ready dropped", {ready_no_dll, ready_dll}, 0);
    wait_for(W_CLKEN_LO, 0, n);
    expect_eq("R9 SRE to clock gate", n, 5);
    clk_stable = 1'b0;
    if (zq_inside) begin zqcs_req = 1'b1; edges(1); zqcs_req = 1'b0; end
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      edges(1);
      if (cke || clk_en_req || cmd != 3'd0) bad++;
    end
    expect_eq("R9 quiet in self-refresh", bad, 0);
    sr_exit_req = 1'b1;
    wait_for(W_CLKEN_HI, 0, n);
    sr_exit_req = 1'b0;
    expect_eq("R10 exit request to clock enable", n, 1);
    edges(3);
    expect_eq("R10 cke low before clock stable", cke, 0);
    clk_stable = 1'b1;
    wait_for(W_CMD, C_SRX, n);
    expect_eq("R10 stable to SRX", n, 5);
    expect_eq("R10 cke high with SRX", cke, 1);
    wait_for(W_RND, 0, n);
    expect_eq("R11 SRX to ready_no_dll", n, 24);
    expect_eq("R11 ready_dll still low", ready_dll, 0);
    wait_for(W_RD, 0, n);
    expect_eq("R11 SRX to ready_dll", n + 24, 512);
    if (zq_inside) begin
      wait_for(W_CMD, C_ZQCS, n);
      expect_eq("R12 held ZQCS after ready", n, 1);
      wait_for(W_RD, 0, n);
      expect_eq("R12 held ZQCS duration", n, 64);
    end
  endtask

  task automatic t_priority();
    int n;
    zqcs_req = 1'b1;
    sr_enter_req = 1'b1;
    wait_for(W_CMD, C_ZQCS, n);
    zqcs_req = 1'b0;
    expect_eq("R13 ZQCS served first", n, 1);
    wait_for(W_CMD, C_SRE, n);
    sr_enter_req = 1'b0;
    expect_eq("R13 ZQCS to SRE", n, 65);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_zq_idle();
    t_sr_cycle(1'b0);
    t_sr_cycle(1'b1);
    t_priority();
    expect_eq("R6 single-cycle commands", r6_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule